// File: doc/BRIEF.md
# Tiled Signed-Integer Matrix Multiplier

This engine forms the product C = A × B of two square matrices whose order N is given at run time (1 up to the parameter `MAX_N`). All three matrices live row-major in an external word-addressed memory. The element (r, c) of a matrix at base address X sits at X + r·N + c. Operands are 16-bit signed. Results are 32-bit two's-complement sums that wrap on overflow.

The output is produced one 16×16 block at a time. For each output block the engine walks the inner dimension in steps of 16. Each step has three parts:
- A load phase copies one 16×16 slice of A and one of B into two local buffers. Positions that fall outside the matrix are written as zero and are never fetched.
- A single-cycle drain lets the last fetched word land.
- A compute phase adds a 16-term dot product into each of the 256 running sums, one sum per cycle.

After the last inner step, the sums that lie inside the matrix are written back. Software loads N and the three base addresses, then pulses `start`. It waits for the one-cycle `done` pulse.

The memory port has a fixed latency and no back-pressure. A request (`mem_req` high) is accepted in the cycle it is shown. For a read (`mem_we` low), the word must appear on `mem_rdata` in the next cycle. For a write, `mem_wdata` is valid in the request cycle. The memory must be able to take one request in every cycle.

Top module: `tmm_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done` and `mem_req` are all low.
- R2: `start` is taken only while idle and only if 1 ≤ `n_size` ≤ `MAX_N`. When it is taken, `busy` is high in the next cycle. A start with N = 0 or N > `MAX_N` leaves the engine idle: no memory request is made and `done` does not pulse.
- R3: Each result word equals the sum over k of A[r][k]·B[k][c], with the operands read as 16-bit two's complement, summed modulo 2^32, and stored at `base_c` + r·N + c.
- R4: For each output block, the inner dimension is walked in ceil(N/16) steps. A and B are read only at addresses inside their N·N regions. Padding positions are never fetched. One run therefore makes exactly 2·N²·ceil(N/16) reads.
- R5: Every address inside the C region is written exactly once per run. No write falls outside it.
- R6: A read is a request with `mem_we` low. The operand is taken from `mem_rdata` in the following cycle only, and `mem_rdata` is ignored in every other cycle. Requests occur only while `busy` is high.
- R7: Both operand buffers are completely filled before any sum of that step is updated. No buffer is written while sums are being updated.
- R8: `done` is high for exactly one cycle per run, in the cycle after the final store-phase cycle. When N is a multiple of 16, that is the cycle right after the last write. `busy` is low in the `done` cycle.
- R9: A `start` pulse while a run is in progress has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (see R2) |
| n_size | input | $clog2(MAX_N+1) (7) | Matrix order N |
| base_a | input | AW (16) | Word address of A[0][0] |
| base_b | input | AW (16) | Word address of B[0][0] |
| base_c | input | AW (16) | Word address of C[0][0] |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| mem_req | output | 1 | Memory request this cycle |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW (16) | Word address |
| mem_wdata | output | ACC_W (32) | Result word for a write |
| mem_rdata | input | OPW (16) | Operand word, one cycle after a read request |

## Verification
Some properties are checked by assertions on every cycle:
- no sum is updated while a buffer write is still pending;
- every write lands inside the C region;
- every read lands inside A or B;
- `done` lasts one cycle and follows the store phase;
- an out-of-range start leaves the engine idle;
- requests occur only while busy.

Other properties can only be shown by the bench scenarios, because each depends on a complete run. These are:
- correct sums under wrap-around with all operands at the most negative value;
- zero padding for N of 1, 15, 17, 20 and 33;
- the exact read count that follows from skipped padding;
- one write per result;
- ignoring a start pulse in mid-run.

// File: rtl/tmm_pkg.sv
package tmm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_DRAIN,
    ST_MAC,
    ST_STORE,
    ST_FIN
  } phase_t;

endpackage

// File: rtl/tmm_tile_buf.sv
// Square operand scratchpad. One element is written per cycle.
// A whole row (COL_READ=0) or a whole column (COL_READ=1) is read combinationally.
module tmm_tile_buf #(
  parameter int TILE     = 16,
  parameter int OPW      = 16,
  parameter bit COL_READ = 1'b0,
  localparam int LW = $clog2(TILE),
  localparam int IW = 2 * LW
) (
  input  logic                  clk,
  input  logic                  wr_en,
  input  logic [IW-1:0]         wr_idx,
  input  logic [OPW-1:0]        wr_data,
  input  logic [LW-1:0]         line_sel,
  output logic [TILE*OPW-1:0]   line
);

  logic [OPW-1:0] cells [TILE*TILE];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_idx] <= wr_data;
  end

  // Element index is {row, col}; the read direction is chosen by COL_READ.
  for (genvar j = 0; j < TILE; j++) begin : g_line
    if (COL_READ) begin : g_col
      assign line[j*OPW +: OPW] = cells[{LW'(j), line_sel}];
    end else begin : g_row
      assign line[j*OPW +: OPW] = cells[{line_sel, LW'(j)}];
    end
  end

endmodule

// File: rtl/tmm_dot.sv
// TILE-term signed dot product, fully parallel.
module tmm_dot #(
  parameter int TILE  = 16,
  parameter int OPW   = 16,
  parameter int ACC_W = 32
) (
  input  logic [TILE*OPW-1:0] a_line,
  input  logic [TILE*OPW-1:0] b_line,
  output logic [ACC_W-1:0]    sum
);

  logic signed [2*OPW-1:0] prod [TILE];

  for (genvar j = 0; j < TILE; j++) begin : g_mul
    assign prod[j] = $signed(a_line[j*OPW +: OPW]) * $signed(b_line[j*OPW +: OPW]);
  end

  always_comb begin
    sum = '0;
    for (int j = 0; j < TILE; j++) begin
      sum = sum + ACC_W'(prod[j]);
    end
  end

endmodule

// File: rtl/tmm_acc.sv
// Running sums, one per element of the output block.
module tmm_acc #(
  parameter int TILE  = 16,
  parameter int ACC_W = 32,
  localparam int IW = 2 * $clog2(TILE)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic             first,
  input  logic [IW-1:0]    idx,
  input  logic [ACC_W-1:0] addend,
  output logic [ACC_W-1:0] rd_data
);

  logic [ACC_W-1:0] cells [TILE*TILE];

  // The first inner step overwrites the sum, so no clear pass is needed.
  always_ff @(posedge clk) begin
    if (wr_en) cells[idx] <= first ? addend : cells[idx] + addend;
  end

  assign rd_data = cells[idx];

endmodule

// File: rtl/tmm_seq.sv
// Phase sequencer: walks output blocks and inner steps,
// and produces the memory addresses and the buffer write strobes.
module tmm_seq
  import tmm_pkg::*;
#(
  parameter int TILE  = 16,
  parameter int MAX_N = 64,
  parameter int AW    = 16,
  localparam int LW    = $clog2(TILE),
  localparam int IW    = 2 * LW,
  localparam int NW    = $clog2(MAX_N + 1),
  localparam int MAX_T = (MAX_N + TILE - 1) / TILE,
  localparam int TW    = (MAX_T < 2) ? 1 : $clog2(MAX_T + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] n_size,
  input  logic [AW-1:0] base_a,
  input  logic [AW-1:0] base_b,
  input  logic [AW-1:0] base_c,
  output logic          busy,
  output logic          done,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic          a_wr,
  output logic          b_wr,
  output logic [IW-1:0] wr_idx,
  output logic          wr_zero,
  output logic          mac_en,
  output logic          mac_first,
  output logic [IW-1:0] elem_idx
);

  localparam logic [IW:0]   LOAD_LAST = (IW+1)'(2 * TILE * TILE - 1);
  localparam logic [IW-1:0] ELEM_LAST = '1;

  phase_t        phase;
  logic [NW-1:0] n_q;
  logic [AW-1:0] ba_q, bb_q, bc_q;
  logic [TW-1:0] nt_q, tr, tc, kt, t_last, nt_new;
  logic [IW:0]   cnt;

  logic          cap_vld, cap_b, cap_zero;
  logic [IW-1:0] cap_idx;

  logic [IW-1:0] eidx;
  logic [LW-1:0] ey, ex;
  logic          ld_b, start_ok;

  logic [AW-1:0] r_pos, c_pos, base_sel, lin_addr, n_w, nn;
  logic          in_rng;

  assign eidx     = cnt[IW-1:0];
  assign ey       = eidx[IW-1:LW];
  assign ex       = eidx[LW-1:0];
  assign ld_b     = cnt[IW];
  assign t_last   = nt_q - TW'(1);
  assign start_ok = start && (n_size != '0) && (n_size <= NW'(MAX_N));
  assign nt_new   = TW'(({1'b0, n_size} + (NW+1)'(TILE - 1)) >> LW);

  // Position of the current element within the full matrix, and its linear address.
  always_comb begin
    n_w = AW'(n_q);
    nn  = n_w * n_w;
    if (phase == ST_LOAD && !ld_b) begin
      r_pos    = AW'({tr, ey});
      c_pos    = AW'({kt, ex});
      base_sel = ba_q;
    end else if (phase == ST_LOAD) begin
      r_pos    = AW'({kt, ey});
      c_pos    = AW'({tc, ex});
      base_sel = bb_q;
    end else begin
      r_pos    = AW'({tr, ey});
      c_pos    = AW'({tc, ex});
      base_sel = bc_q;
    end
    in_rng   = (r_pos < n_w) && (c_pos < n_w);
    lin_addr = base_sel + r_pos * n_w + c_pos;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= ST_IDLE;
      n_q   <= '0;
      ba_q  <= '0;
      bb_q  <= '0;
      bc_q  <= '0;
      nt_q  <= '0;
      tr    <= '0;
      tc    <= '0;
      kt    <= '0;
      cnt   <= '0;
    end else begin
      case (phase)
        ST_IDLE: begin
          if (start_ok) begin
            n_q   <= n_size;
            ba_q  <= base_a;
            bb_q  <= base_b;
            bc_q  <= base_c;
            nt_q  <= nt_new;
            tr    <= '0;
            tc    <= '0;
            kt    <= '0;
            cnt   <= '0;
            phase <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (cnt == LOAD_LAST) begin
            cnt   <= '0;
            phase <= ST_DRAIN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DRAIN: phase <= ST_MAC;
        ST_MAC: begin
          if (eidx == ELEM_LAST) begin
            cnt <= '0;
            if (kt == t_last) begin
              kt    <= '0;
              phase <= ST_STORE;
            end else begin
              kt    <= kt + 1'b1;
              phase <= ST_LOAD;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STORE: begin
          if (eidx == ELEM_LAST) begin
            cnt <= '0;
            if (tc == t_last) begin
              tc <= '0;
              if (tr == t_last) begin
                tr    <= '0;
                phase <= ST_FIN;
              end else begin
                tr    <= tr + 1'b1;
                phase <= ST_LOAD;
              end
            end else begin
              tc    <= tc + 1'b1;
              phase <= ST_LOAD;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_FIN:  phase <= ST_IDLE;
        default: phase <= ST_IDLE;
      endcase
    end
  end

  // Read-return capture: a fetched word (or a zero for a padding position) lands one cycle later.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_vld  <= 1'b0;
      cap_b    <= 1'b0;
      cap_zero <= 1'b0;
      cap_idx  <= '0;
    end else begin
      cap_vld  <= (phase == ST_LOAD);
      cap_b    <= ld_b;
      cap_zero <= !in_rng;
      cap_idx  <= eidx;
    end
  end

  assign mem_req   = ((phase == ST_LOAD) || (phase == ST_STORE)) && in_rng;
  assign mem_we    = (phase == ST_STORE) && in_rng;
  assign mem_addr  = mem_req ? lin_addr : '0;
  assign a_wr      = cap_vld && !cap_b;
  assign b_wr      = cap_vld && cap_b;
  assign wr_idx    = cap_idx;
  assign wr_zero   = cap_zero;
  assign mac_en    = (phase == ST_MAC);
  assign mac_first = (kt == '0);
  assign elem_idx  = eidx;
  assign busy      = (phase != ST_IDLE) && (phase != ST_FIN);
  assign done      = (phase == ST_FIN);

  // R7: sums are never updated while a buffer write is still pending
  p_fill_before_mac_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mac_en |-> !(a_wr || b_wr));

  // R5: writes stay inside the C region
  p_write_in_c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((mem_addr - bc_q) < nn));

  // R4: reads stay inside the A or B region
  p_read_in_ab_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (((mem_addr - ba_q) < nn) || ((mem_addr - bb_q) < nn)));

  // R8: done lasts a single cycle
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: done directly follows the store phase
  p_done_after_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(phase) == ST_STORE));

  // R2: an out-of-range order leaves the engine idle
  p_bad_n_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == ST_IDLE) && start && !start_ok) |=> (phase == ST_IDLE));

  // R6: memory traffic only during a run
  p_req_only_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

endmodule

// File: rtl/tmm_engine.sv
module tmm_engine
  import tmm_pkg::*;
#(
  parameter int MAX_N = 64,
  parameter int TILE  = 16,
  parameter int OPW   = 16,
  parameter int ACC_W = 32,
  parameter int AW    = 16,
  localparam int NW   = $clog2(MAX_N + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NW-1:0]    n_size,
  input  logic [AW-1:0]    base_a,
  input  logic [AW-1:0]    base_b,
  input  logic [AW-1:0]    base_c,
  output logic             busy,
  output logic             done,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [ACC_W-1:0] mem_wdata,
  input  logic [OPW-1:0]   mem_rdata
);

  localparam int LW = $clog2(TILE);
  localparam int IW = 2 * LW;

  logic                a_wr, b_wr, wr_zero, mac_en, mac_first;
  logic [IW-1:0]       wr_idx, elem_idx;
  logic [OPW-1:0]      wr_data;
  logic [TILE*OPW-1:0] a_line, b_line;
  logic [ACC_W-1:0]    dot_sum;

  // Padding positions are filled with zero instead of the (unfetched) bus value.
  assign wr_data = wr_zero ? '0 : mem_rdata;

  tmm_seq #(.TILE(TILE), .MAX_N(MAX_N), .AW(AW)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .n_size    (n_size),
    .base_a    (base_a),
    .base_b    (base_b),
    .base_c    (base_c),
    .busy      (busy),
    .done      (done),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .a_wr      (a_wr),
    .b_wr      (b_wr),
    .wr_idx    (wr_idx),
    .wr_zero   (wr_zero),
    .mac_en    (mac_en),
    .mac_first (mac_first),
    .elem_idx  (elem_idx)
  );

  tmm_tile_buf #(.TILE(TILE), .OPW(OPW), .COL_READ(1'b0)) buf_a_i (
    .clk      (clk),
    .wr_en    (a_wr),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .line_sel (elem_idx[IW-1:LW]),
    .line     (a_line)
  );

  tmm_tile_buf #(.TILE(TILE), .OPW(OPW), .COL_READ(1'b1)) buf_b_i (
    .clk      (clk),
    .wr_en    (b_wr),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .line_sel (elem_idx[LW-1:0]),
    .line     (b_line)
  );

  tmm_dot #(.TILE(TILE), .OPW(OPW), .ACC_W(ACC_W)) dot_i (
    .a_line (a_line),
    .b_line (b_line),
    .sum    (dot_sum)
  );

  tmm_acc #(.TILE(TILE), .ACC_W(ACC_W)) acc_i (
    .clk     (clk),
    .wr_en   (mac_en),
    .first   (mac_first),
    .idx     (elem_idx),
    .addend  (dot_sum),
    .rd_data (mem_wdata)
  );

  // R6: write and read strobes are coherent at the edge
  p_we_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);

endmodule

// File: tb/tmm_engine_tb_top.sv
`timescale 1ns/1ps
module tmm_engine_tb_top;

  localparam int NW  = 7;
  localparam int AW  = 16;
  localparam int A_B = 0;
  localparam int B_B = 2048;
  localparam int C_B = 4096;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [NW-1:0] n_size = '0;
  logic [AW-1:0] base_a = AW'(A_B);
  logic [AW-1:0] base_b = AW'(B_B);
  logic [AW-1:0] base_c = AW'(C_B);
  logic          busy, done, mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic [15:0]   mem_rdata = '0;

  always #4 clk = ~clk;

  tmm_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .n_size(n_size),
    .base_a(base_a), .base_b(base_b), .base_c(base_c),
    .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [31:0] mem_arr [8192];
  int wcount [4096];
  int cur_n = 1;
  int cyc = 0, rd_cnt = 0, bad_rd = 0, bad_wr = 0, req_cnt = 0;
  int done_cnt = 0, done_cyc = 0, last_wr_cyc = 0;
  int checks = 0, errors = 0;
  bit dead = 1'b0;

  // Memory: read data one cycle after the request, random noise otherwise.
  always @(posedge clk) begin
    if (mem_req && !mem_we && int'(mem_addr) < 8192) mem_rdata <= mem_arr[mem_addr][15:0];
    else mem_rdata <= 16'($urandom);
    if (mem_req && mem_we && int'(mem_addr) < 8192) mem_arr[mem_addr] <= mem_wdata;
  end

  // Traffic monitor (reads the values held through the ending cycle).
  always @(posedge clk) begin
    int a;
    int nn;
    a  = int'(mem_addr);
    nn = cur_n * cur_n;
    cyc++;
    if (mem_req) begin
      req_cnt++;
      if (mem_we) begin
        if (a >= C_B && a < C_B + nn) begin
          wcount[a - C_B]++;
          last_wr_cyc = cyc;
        end else bad_wr++;
      end else begin
        if ((a >= A_B && a < A_B + nn) || (a >= B_B && a < B_B + nn)) rd_cnt++;
        else bad_rd++;
      end
    end
    if (done) begin
      done_cnt++;
      done_cyc = cyc;
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_c(int n, int r, int c);
    logic [31:0] s = '0;
    for (int k = 0; k < n; k++) begin
      int p;
      p = int'(shortint'(mem_arr[A_B + r*n + k][15:0])) *
          int'(shortint'(mem_arr[B_B + k*n + c][15:0]));
      s = s + 32'(p);
    end
    return s;
  endfunction

  // pat 0: random operands; pat 1: every operand at -32768
  task automatic run_case(int n, int pat, bit poke);
    int w, mism, first_r, bad_cnt, nt;
    logic [31:0] fa, fe;
    for (int i = 0; i < n*n; i++) begin
      mem_arr[A_B + i] = (pat == 1) ? 32'h8000 : ($urandom & 32'hFFFF);
      mem_arr[B_B + i] = (pat == 1) ? 32'h8000 : ($urandom & 32'hFFFF);
    end
    for (int i = 0; i < 4096; i++) begin
      mem_arr[C_B + i] = 32'h5A5A5A5A;
      wcount[i] = 0;
    end
    @(negedge clk);
    cur_n = n; rd_cnt = 0; bad_rd = 0; bad_wr = 0; done_cnt = 0; last_wr_cyc = 0;
    start = 1'b1; n_size = NW'(n);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", $sformatf("busy after accepted start N=%0d", n), busy, 1);
    w = 0;
    while (done_cnt == 0 && w < 60000) begin
      @(negedge clk);
      w++;
      if (poke && w == 300) begin start = 1'b1; n_size = NW'(5); end
      else if (poke && w == 301) start = 1'b0;
    end
    if (done_cnt == 0) begin
      chk(1'b0, "R8", "watchdog expired before done", w, 0);
      dead = 1'b1;
      return;
    end
    repeat (3) @(negedge clk);
    // R3 R6 R7: result values
    mism = 0; fa = '0; fe = '0; first_r = -1;
    for (int r = 0; r < n; r++)
      for (int c = 0; c < n; c++) begin
        logic [31:0] e;
        e = exp_c(n, r, c);
        if (mem_arr[C_B + r*n + c] !== e) begin
          if (mism == 0) begin fa = mem_arr[C_B + r*n + c]; fe = e; first_r = r*n + c; end
          mism++;
        end
      end
    chk(mism == 0, "R3 R6 R7", $sformatf("N=%0d first bad word %0d", n, first_r), fa, fe);
    // R5: each result written once, nothing outside C
    bad_cnt = 0;
    for (int i = 0; i < n*n; i++) if (wcount[i] != 1) bad_cnt++;
    chk(bad_cnt == 0 && bad_wr == 0, "R5", $sformatf("N=%0d miswritten words", n), bad_cnt + bad_wr, 0);
    // R4: read count and read ranges
    nt = (n + 15) / 16;
    chk(rd_cnt == 2*n*n*nt && bad_rd == 0, "R4", $sformatf("N=%0d operand reads", n), rd_cnt, 2*n*n*nt);
    // R8: single done, busy released, timing against last write
    chk(done_cnt == 1 && busy == 1'b0, "R8", $sformatf("N=%0d done pulses", n), done_cnt, 1);
    if (n % 16 == 0)
      chk(done_cyc == last_wr_cyc + 1, "R8", $sformatf("N=%0d done cycle vs last write", n), done_cyc, last_wr_cyc + 1);
    else
      chk(done_cyc > last_wr_cyc, "R8", $sformatf("N=%0d done after last write", n), done_cyc - last_wr_cyc, 1);
    if (poke)
      chk(done_cnt == 1 && mism == 0, "R9", "start during run ignored", mism, 0);
  endtask

  task automatic bad_start(int n);
    int r0;
    @(negedge clk);
    r0 = req_cnt; done_cnt = 0;
    start = 1'b1; n_size = NW'(n);
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && req_cnt == r0 && done_cnt == 0, "R2",
        $sformatf("start with N=%0d ignored (busy, reqs, dones)", n), busy + req_cnt - r0 + done_cnt, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && mem_req == 0, "R1", "outputs in reset", {busy, done, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && mem_req == 0, "R1", "outputs after reset", {busy, done, mem_req}, 0);
    bad_start(0);
    bad_start(65);
    if (!dead) run_case(16, 1, 1'b0);
    if (!dead) run_case(1, 0, 1'b0);
    if (!dead) run_case(15, 0, 1'b0);
    if (!dead) run_case(16, 0, 1'b0);
    if (!dead) run_case(17, 0, 1'b0);
    if (!dead) run_case(20, 0, 1'b1);
    if (!dead) run_case(33, 0, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule